// File: doc/BRIEF.md
# Q-ary Galois Feedback Shift Register

This block is a feedback shift register in Galois form whose cells each hold one symbol from the integer alphabet 0..q-1 rather than a single bit. On every enabled step the symbol leaving the last stage is fed back. Each stage i takes the symbol of stage i-1 and adds to it, modulo q, the fed-back symbol times a fixed coefficient chosen for that stage. Stage 0 receives only its own product term. The stage count, the modulus and the per-stage coefficients are compile-time parameters. It serves as a compact generator of pseudo-random symbol streams, for example as a multi-level test pattern source.

The register is seeded through a load port. Seed symbols that do not fit the alphabet are folded back into range. A seed that would leave every stage at zero is refused, because zero is a lock-up state. The refusal is reported on a flag and the previous contents are kept. With q = 2 and coefficients of 0 or 1, the structure is an ordinary binary Galois LFSR.

Top module: `qfsr_galois`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes stage 0 = 1 and all other stages = 0, and `seed_invalid` becomes 0.
- R2: At an edge where neither `seed_load` nor `step_en` is high, `state_vec` and `out_sym` keep their values.
- R3: At an edge with `step_en` high and `seed_load` low, with o = stage N-1, the new stage 0 is (c0·o) mod q and the new stage i (i ≥ 1) is (stage i-1 + ci·o) mod q. Coefficient ci sits in bits [8i+7:8i] of `TAP_COEF`. Stage i occupies bits [iW+W-1:iW] of `state_vec`, where W = ceil(log2 q), and `out_sym` always equals stage N-1.
- R4: At an edge with `seed_load` high and a seed that is not all zero after conditioning, the state becomes the conditioned seed on that edge and `seed_invalid` becomes 0.
- R5: Each W-bit seed symbol s, at bits [iW+W-1:iW] of `seed_value`, is conditioned to s-q when s ≥ q and kept as s otherwise.
- R6: At an edge with `seed_load` high and every conditioned seed symbol zero, the state is unchanged and `seed_invalid` becomes 1. The flag then stays 1 through steps and holds until a valid load or a reset.
- R7: When `seed_load` and `step_en` are both high, the load is performed and no step is taken.
- R8: With q = 2, coefficients c0 = c1 = 1 and the others 0, over four stages, the sequence equals the binary Galois XOR recurrence and first returns to the reset state after 15 steps.
- R9: Every stage symbol is always below q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the register by one step |
| seed_load | input | 1 | Load `seed_value` (takes priority over a step) |
| seed_value | input | N_STAGES*W | Seed symbols, stage i in bits [iW+W-1:iW] |
| out_sym | output | W | Symbol of the last stage |
| state_vec | output | N_STAGES*W | All stage symbols, stage i in bits [iW+W-1:iW] |
| seed_invalid | output | 1 | Last load was refused as all zero |

## Verification
The bench builds one instance with three stages, q = 5 (W = 3) and coefficients 1, 3, 2. This makes the full recurrence checkable step by step over 375 steps, three times q^N. The 3-bit symbols also reach the out-of-range seed values 5, 6 and 7, so the conditioning and a seed that only becomes zero after folding can both be exercised. A second instance with four stages and q = 2 runs the binary special case, where the known period of 15 gives a check that does not depend on the stepping model.

// File: rtl/qfsr_pkg.sv
package qfsr_pkg;
  localparam int COEF_BITS = 8;

  function automatic int sym_width(input int q);
    return (q <= 2) ? 1 : $clog2(q);
  endfunction
endpackage

// File: rtl/qfsr_tap_cell.sv
module qfsr_tap_cell #(
  parameter int Q = 5,
  parameter int W = 3,
  parameter logic [qfsr_pkg::COEF_BITS-1:0] COEF = 8'd1
) (
  input  logic [W-1:0] addend,
  input  logic [W-1:0] fb,
  output logic [W-1:0] sum
);
  localparam logic [W:0] QV = (W+1)'(Q);
  localparam logic [qfsr_pkg::COEF_BITS-1:0] C_RED = qfsr_pkg::COEF_BITS'(COEF % Q);

  logic [W:0] acc;

  // double-and-add multiply by the constant, each partial kept below Q
  always_comb begin
    acc = '0;
    for (int k = qfsr_pkg::COEF_BITS-1; k >= 0; k--) begin
      acc = {acc[W-1:0], 1'b0};
      if (acc >= QV) acc = acc - QV;
      if (C_RED[k]) begin
        acc = acc + {1'b0, fb};
        if (acc >= QV) acc = acc - QV;
      end
    end
    acc = acc + {1'b0, addend};
    if (acc >= QV) acc = acc - QV;
    sum = acc[W-1:0];
  end
endmodule

// File: rtl/qfsr_seed_cond.sv
module qfsr_seed_cond #(
  parameter int N_STAGES = 4,
  parameter int Q = 5,
  parameter int W = 3
) (
  input  logic [N_STAGES*W-1:0] raw,
  output logic [N_STAGES*W-1:0] folded,
  output logic                  all_zero
);
  localparam logic [W:0] QV = (W+1)'(Q);

  logic [N_STAGES-1:0] sym_nz;

  genvar g;
  generate
    for (g = 0; g < N_STAGES; g++) begin : g_sym
      logic [W:0] wide;
      logic [W:0] diff;
      assign wide = {1'b0, raw[g*W +: W]};
      assign diff = wide - QV;
      assign folded[g*W +: W] = (wide >= QV) ? diff[W-1:0] : wide[W-1:0];
      assign sym_nz[g] = |folded[g*W +: W];
    end
  endgenerate

  assign all_zero = ~|sym_nz;
endmodule

// File: rtl/qfsr_galois.sv
module qfsr_galois #(
  parameter int N_STAGES = 4,
  parameter int Q = 5,
  parameter logic [qfsr_pkg::COEF_BITS*N_STAGES-1:0] TAP_COEF = 32'h0301_0002,
  localparam int W = qfsr_pkg::sym_width(Q)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step_en,
  input  logic                  seed_load,
  input  logic [N_STAGES*W-1:0] seed_value,
  output logic [W-1:0]          out_sym,
  output logic [N_STAGES*W-1:0] state_vec,
  output logic                  seed_invalid
);
  localparam int CB = qfsr_pkg::COEF_BITS;
  localparam logic [N_STAGES*W-1:0] RST_VEC = (N_STAGES*W)'(1);
  localparam logic [W:0] QV = (W+1)'(Q);

  logic [N_STAGES-1:0][W-1:0] st;
  logic [N_STAGES-1:0][W-1:0] nxt;
  logic [N_STAGES*W-1:0]      seed_red;
  logic                       seed_all_zero;

  qfsr_seed_cond #(.N_STAGES(N_STAGES), .Q(Q), .W(W)) u_seed (
    .raw      (seed_value),
    .folded   (seed_red),
    .all_zero (seed_all_zero)
  );

  genvar i;
  generate
    for (i = 0; i < N_STAGES; i++) begin : g_stage
      logic [W-1:0] prev;
      if (i == 0) begin : g_head
        assign prev = '0;
      end else begin : g_body
        assign prev = st[i-1];
      end
      qfsr_tap_cell #(.Q(Q), .W(W), .COEF(TAP_COEF[CB*i +: CB])) u_cell (
        .addend (prev),
        .fb     (st[N_STAGES-1]),
        .sum    (nxt[i])
      );

      // R9
      sym_range_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, st[i]} < QV);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= RST_VEC;
      seed_invalid <= 1'b0;
    end else if (seed_load) begin
      if (seed_all_zero) begin
        seed_invalid <= 1'b1;
      end else begin
        st           <= seed_red;
        seed_invalid <= 1'b0;
      end
    end else if (step_en) begin
      st <= nxt;
    end
  end

  assign state_vec = st;
  assign out_sym   = st[N_STAGES-1];

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && !step_en) |=> $stable(st));

  // R6
  zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_all_zero) |=> ($stable(st) && seed_invalid));

  // R4 R7
  seed_take_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_load && !seed_all_zero) |=> (st == $past(seed_red) && !seed_invalid));
endmodule

// File: tb/sim_qfsr_galois.sv
module sim_qfsr_galois;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       step0 = 1'b0, load0 = 1'b0;
  logic [8:0] seed0 = '0;
  logic [2:0] out0;
  logic [8:0] st0;
  logic       inv0;

  logic       step1 = 1'b0, load1 = 1'b0;
  logic [3:0] seed1 = '0;
  logic [0:0] out1;
  logic [3:0] st1;
  logic       inv1;

  qfsr_galois #(.N_STAGES(3), .Q(5), .TAP_COEF(24'h02_03_01)) u0 (
    .clk(clk), .rst(rst), .step_en(step0), .seed_load(load0), .seed_value(seed0),
    .out_sym(out0), .state_vec(st0), .seed_invalid(inv0));

  qfsr_galois #(.N_STAGES(4), .Q(2), .TAP_COEF(32'h0000_0101)) u1 (
    .clk(clk), .rst(rst), .step_en(step1), .seed_load(load1), .seed_value(seed1),
    .out_sym(out1), .state_vec(st1), .seed_invalid(inv1));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m0 [3];
  int minv0;
  int m1 [4];
  int cf [3] = '{1, 3, 2};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] pk0();
    return {3'(m0[2]), 3'(m0[1]), 3'(m0[0])};
  endfunction

  task automatic check0(input string req);
    chk(req, 32'(st0), 32'(pk0()));
    chk(req, 32'(out0), 32'(m0[2]));
    chk(req, 32'(inv0), 32'(minv0));
  endtask

  // one cycle on u0, inputs set at negedge, model follows the requirements
  task automatic cyc0(input logic s, input logic l, input logic [8:0] sv);
    int r [3];
    int o;
    int n [3];
    step0 = s; load0 = l; seed0 = sv;
    @(posedge clk);
    @(negedge clk);
    step0 = 0; load0 = 0;
    if (l) begin
      for (int k = 0; k < 3; k++) begin
        r[k] = int'(sv[3*k +: 3]);
        if (r[k] >= 5) r[k] -= 5;
      end
      if (r[0] == 0 && r[1] == 0 && r[2] == 0) minv0 = 1;
      else begin m0 = r; minv0 = 0; end
    end else if (s) begin
      o = m0[2];
      n[0] = (cf[0] * o) % 5;
      for (int k = 1; k < 3; k++) n[k] = (m0[k-1] + cf[k] * o) % 5;
      m0 = n;
    end
  endtask

  task automatic cyc1(input logic s);
    int o;
    step1 = s;
    @(posedge clk);
    @(negedge clk);
    step1 = 0;
    if (s) begin
      o = m1[3];
      m1[3] = m1[2];
      m1[2] = m1[1];
      m1[1] = m1[0] ^ o;
      m1[0] = o;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m0 = '{1, 0, 0}; minv0 = 0;
    m1 = '{1, 0, 0, 0};
    check0("R1");
    chk("R1", 32'(st1), 32'h1);
    chk("R1", 32'(inv1), 32'h0);
  endtask

  task automatic t_run_full();
    for (int k = 0; k < 375; k++) begin
      cyc0(1'b1, 1'b0, '0);
      check0("R3");
    end
  endtask

  task automatic t_hold();
    for (int k = 0; k < 4; k++) begin
      cyc0(1'b0, 1'b0, 9'h1ff);
      check0("R2");
    end
  endtask

  task automatic t_seed();
    cyc0(1'b0, 1'b1, {3'd4, 3'd2, 3'd3});
    check0("R4");
    for (int k = 0; k < 40; k++) begin
      cyc0(k[0], 1'b0, '0);
      check0((k[0]) ? "R3" : "R2");
    end
  endtask

  task automatic t_reduce();
    cyc0(1'b0, 1'b1, {3'd7, 3'd6, 3'd5});
    check0("R5");
    chk("R5", 32'(st0), 32'({3'd2, 3'd1, 3'd0}));
  endtask

  task automatic t_zero();
    cyc0(1'b0, 1'b1, 9'h000);
    check0("R6");
    chk("R6", 32'(inv0), 32'h1);
    cyc0(1'b1, 1'b0, '0);
    check0("R6");
    cyc0(1'b0, 1'b1, {3'd5, 3'd5, 3'd5});
    check0("R6");
    cyc0(1'b0, 1'b1, {3'd0, 3'd0, 3'd1});
    check0("R6");
    chk("R6", 32'(inv0), 32'h0);
  endtask

  task automatic t_priority();
    cyc0(1'b1, 1'b1, {3'd1, 3'd4, 3'd2});
    check0("R7");
    chk("R7", 32'(st0), 32'({3'd1, 3'd4, 3'd2}));
  endtask

  task automatic t_binary();
    int first;
    first = 0;
    for (int k = 1; k <= 20; k++) begin
      cyc1(1'b1);
      chk("R8", 32'(st1), 32'({m1[3][0], m1[2][0], m1[1][0], m1[0][0]}));
      chk("R8", 32'(out1), 32'(m1[3]));
      if (first == 0 && st1 == 4'h1) first = k;
    end
    chk("R8", 32'(first), 32'd15);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_hold();
    t_run_full();
    t_seed();
    t_reduce();
    t_zero();
    t_priority();
    t_binary();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule